// File: doc/BRIEF.md
# Embedded operation status flag generator

This block builds the byte a flash device hands back on a read while an internal program or erase runs or sits suspended. A small mode machine follows operation events (program start, erase start, suspend, resume, finish) from the sequencer. On each read strobe the block looks at the mode, the sector the read address falls in, the set of sectors chosen for erase, the timeout flag, the erase acceptance window and the byte being programmed. It then returns either a status byte or the array data unchanged. Two flags in the status byte invert on successive reads. A host polls them to tell a running operation from a finished or suspended one.

The read response is registered. A strobe in cycle t gives `rd_valid` and `rd_data` in cycle t+1. The byte reflects the mode and toggle values held before any event given in the same cycle t. The sector index is the top `$clog2(NSECT)` bits of the read address. Bit `i` of `erase_sel` marks sector `i` as chosen for erase.

The modes are ARRAY, PROG, ERASE, SUSP and SUSP_PROG. Events are coded on `op_evt` as 0 none, 1 program start, 2 erase start, 3 suspend, 4 resume and 5 finish. The transitions are:
- ARRAY goes to PROG on event 1 and to ERASE on event 2.
- PROG goes to ARRAY on event 5.
- ERASE goes to SUSP on event 3 and to ARRAY on event 5.
- SUSP goes to ERASE on event 4, to SUSP_PROG on event 1 and to ARRAY on event 5.
- SUSP_PROG goes back to SUSP on event 5.

Top module: `esf_top`

## Requirements
- R1: After reset the mode is ARRAY, `rd_valid` is 0 and `rd_data` is 0x00.
- R2: `rd_valid` is high exactly in the cycle after a read strobe. In ARRAY mode, and in SUSP mode for a sector not selected for erase, `rd_data` equals `array_data` as sampled with the strobe.
- R3: In PROG and SUSP_PROG modes, bit 7 is the inverse of `prog_byte[7]`. Bits 3 and 2 are 0.
- R4: In ERASE mode, bit 7 is 0 and bit 3 is the inverse of `win_open`. This holds at every address.
- R5: Bit 6 inverts after each read in PROG, ERASE and SUSP_PROG. It holds its value in SUSP mode and in cycles without a read strobe.
- R6: In ERASE and SUSP modes, bit 2 inverts after each read whose sector is selected for erase. A read of any other sector leaves it unchanged.
- R7: A SUSP-mode read of a selected sector returns bit 7 = 1 with bits 5 and 3 = 0.
- R8: Bit 5 equals `time_fail` in PROG, ERASE and SUSP_PROG modes.
- R9: In every status byte, bits 4, 1 and 0 are 0.
- R10: An accepted program start or erase start event clears both toggle bits. This clear takes priority over a flip from a read in the same cycle, so the first status read after the start returns 0 in bits 6 and 2.
- R11: Events not listed for the current mode are ignored. One example is suspend during PROG. Another is suspend or resume in ARRAY.
- R12: Program started from SUSP reports status exactly as R3, R5 and R8 describe. Its finish returns to SUSP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_evt | input | 3 | Operation event code |
| erase_sel | input | NSECT | Sectors selected for erase |
| win_open | input | 1 | Erase acceptance window open |
| time_fail | input | 1 | Operation exceeded its time limit |
| prog_byte | input | 8 | Byte being programmed |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Array byte at the read address |
| rd_valid | output | 1 | Response valid |
| rd_data | output | 8 | Status or array byte |

## Verification
The two functions that can fall in the same cycle are a read strobe and a mode event. The most delicate pairing is a read together with a program or erase start, where a toggle flip and a toggle clear compete. The bench issues an erase start in the same cycle as a read and also pairs reads with suspend, resume and finish events. It then judges that each read reports the pre-event mode. It also judges that the following status read shows both toggles at 0 where a start was accepted, and that they continue in sequence where no start occurred.

// File: rtl/esf_pkg.sv
package esf_pkg;

    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_PROG_GO  = 3'd1,
        EV_ERASE_GO = 3'd2,
        EV_SUSPEND  = 3'd3,
        EV_RESUME   = 3'd4,
        EV_FINISH   = 3'd5
    } evt_e;

    typedef enum logic [2:0] {
        M_ARRAY     = 3'd0,
        M_PROG      = 3'd1,
        M_ERASE     = 3'd2,
        M_SUSP      = 3'd3,
        M_SUSP_PROG = 3'd4
    } mode_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/esf_mode_fsm.sv
module esf_mode_fsm
    import esf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  evt_e  evt,
    output mode_e mode,
    output logic  op_start
);

    mode_e mode_q;
    mode_e mode_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_ARRAY;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_ARRAY: begin
                if (evt == EV_PROG_GO) begin
                    mode_d = M_PROG;
                end else if (evt == EV_ERASE_GO) begin
                    mode_d = M_ERASE;
                end
            end
            M_PROG: begin
                if (evt == EV_FINISH) begin
                    mode_d = M_ARRAY;
                end
            end
            M_ERASE: begin
                if (evt == EV_SUSPEND) begin
                    mode_d = M_SUSP;
                end else if (evt == EV_FINISH) begin
                    mode_d = M_ARRAY;
                end
            end
            M_SUSP: begin
                if (evt == EV_RESUME) begin
                    mode_d = M_ERASE;
                end else if (evt == EV_PROG_GO) begin
                    mode_d = M_SUSP_PROG;
                end else if (evt == EV_FINISH) begin
                    mode_d = M_ARRAY;
                end
            end
            M_SUSP_PROG: begin
                if (evt == EV_FINISH) begin
                    mode_d = M_SUSP;
                end
            end
            default: mode_d = M_ARRAY;
        endcase
    end

    always_comb begin
        op_start = 1'b0;
        unique case (mode_q)
            M_ARRAY:     op_start = (evt == EV_PROG_GO) || (evt == EV_ERASE_GO);
            M_SUSP:      op_start = (evt == EV_PROG_GO);
            M_PROG,
            M_ERASE,
            M_SUSP_PROG: op_start = 1'b0;
            default:     op_start = 1'b0;
        endcase
    end

    assign mode = mode_q;

    AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SUSP) && ($past(mode_q) != M_SUSP) |-> ($past(mode_q) == M_ERASE) || ($past(mode_q) == M_SUSP_PROG)); // R11

    AST_PROG_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == M_PROG) |-> ($past(mode_q) == M_ARRAY)); // R11

    AST_SUSP_PROG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == M_SUSP_PROG) |-> ($past(mode_q) == M_SUSP)); // R12

endmodule

// File: rtl/esf_sector_hit.sv
module esf_sector_hit #(
    parameter int unsigned NSECT  = 8,
    localparam int unsigned SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic [SECT_W-1:0] sect_idx,
    input  logic [NSECT-1:0]  sel_mask,
    output logic              hit
);

    logic [NSECT-1:0] match_vec;

    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        assign match_vec[i] = sel_mask[i] && (sect_idx == SECT_W'(i));
    end

    assign hit = |match_vec;

endmodule

// File: rtl/esf_toggles.sv
module esf_toggles (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic flip6,
    input  logic flip2,
    output logic t6,
    output logic t2
);

    logic t6_q;
    logic t2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
        end else if (clear) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
        end else begin
            if (flip6) begin
                t6_q <= ~t6_q;
            end
            if (flip2) begin
                t2_q <= ~t2_q;
            end
        end
    end

    assign t6 = t6_q;
    assign t2 = t2_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (t6_q == 1'b0) && (t2_q == 1'b0)); // R10

    AST_T6_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !flip6 |=> $stable(t6_q)); // R5

    AST_T2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !flip2 |=> $stable(t2_q)); // R6

endmodule

// File: rtl/esf_view.sv
module esf_view
    import esf_pkg::*;
(
    input  mode_e             mode,
    input  logic              sect_hit,
    input  logic              t6,
    input  logic              t2,
    input  logic              win_open,
    input  logic              time_fail,
    input  logic              pb_msb,
    input  logic [BYTE_W-1:0] array_data,
    output logic [BYTE_W-1:0] byte_out,
    output logic              want6,
    output logic              want2,
    output logic              is_status
);

    always_comb begin
        byte_out  = array_data;
        want6     = 1'b0;
        want2     = 1'b0;
        is_status = 1'b0;
        unique case (mode)
            M_ARRAY: begin
                byte_out = array_data;
            end
            M_PROG, M_SUSP_PROG: begin
                byte_out  = {~pb_msb, t6, time_fail, 5'b00000};
                want6     = 1'b1;
                is_status = 1'b1;
            end
            M_ERASE: begin
                byte_out  = {1'b0, t6, time_fail, 1'b0, ~win_open, t2, 2'b00};
                want6     = 1'b1;
                want2     = sect_hit;
                is_status = 1'b1;
            end
            M_SUSP: begin
                if (sect_hit) begin
                    byte_out  = {1'b1, t6, 3'b000, t2, 2'b00};
                    want2     = 1'b1;
                    is_status = 1'b1;
                end else begin
                    byte_out = array_data;
                end
            end
            default: begin
                byte_out = array_data;
            end
        endcase
    end

endmodule

// File: rtl/esf_top.sv
module esf_top
    import esf_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned NSECT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_evt,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic              win_open,
    input  logic              time_fail,
    input  logic [7:0]        prog_byte,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    localparam int unsigned SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1;
    localparam int unsigned LO_W   = ADDR_W - SECT_W;

    mode_e             mode;
    logic              op_start;
    logic              sect_hit;
    logic              t6;
    logic              t2;
    logic              want6;
    logic              want2;
    logic              is_status;
    logic [BYTE_W-1:0] view_byte;
    logic [SECT_W-1:0] sect_idx;
    logic              rsp_status;
    logic              unused_bits;

    assign sect_idx    = rd_addr[ADDR_W-1 -: SECT_W];
    assign unused_bits = ^{rd_addr[LO_W-1:0], prog_byte[6:0]};

    esf_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_e'(op_evt)),
        .mode     (mode),
        .op_start (op_start)
    );

    esf_sector_hit #(
        .NSECT (NSECT)
    ) u_hit (
        .sect_idx (sect_idx),
        .sel_mask (erase_sel),
        .hit      (sect_hit)
    );

    esf_toggles u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (op_start),
        .flip6 (rd_stb && want6),
        .flip2 (rd_stb && want2),
        .t6    (t6),
        .t2    (t2)
    );

    esf_view u_view (
        .mode       (mode),
        .sect_hit   (sect_hit),
        .t6         (t6),
        .t2         (t2),
        .win_open   (win_open),
        .time_fail  (time_fail),
        .pb_msb     (prog_byte[7]),
        .array_data (array_data),
        .byte_out   (view_byte),
        .want6      (want6),
        .want2      (want2),
        .is_status  (is_status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            rsp_status <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rd_data    <= view_byte;
                rsp_status <= is_status;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid); // R2

    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && (mode == M_ARRAY) |=> rd_data == $past(array_data)); // R2

    AST_ERASE_B7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && (mode == M_ERASE) |=> !rd_data[7]); // R4

    AST_PROG_B7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && ((mode == M_PROG) || (mode == M_SUSP_PROG)) |=> rd_data[7] != $past(prog_byte[7])); // R3

    AST_SUSP_SEL_B7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && (mode == M_SUSP) && sect_hit |=> rd_data[7] && !rd_data[5]); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rsp_status |-> (rd_data[4] == 1'b0) && (rd_data[1] == 1'b0) && (rd_data[0] == 1'b0)); // R9

endmodule

// File: tb/tb_esf_top.sv
module tb_esf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_evt = 3'd0;
    logic [7:0]  erase_sel = 8'b0010_0100;
    logic        win_open = 1'b1;
    logic        time_fail = 1'b0;
    logic [7:0]  prog_byte = 8'h00;
    logic        rd_stb = 1'b0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  array_data;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign array_data = 8'hC3 ^ {5'd0, rd_addr[18:16]};

    esf_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_evt     (op_evt),
        .erase_sel  (erase_sel),
        .win_open   (win_open),
        .time_fail  (time_fail),
        .prog_byte  (prog_byte),
        .rd_stb     (rd_stb),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    // entry: tag[27:24] evt[23:21] sect[20:18] win[17] fail[16] pbyte[15:8] expect[7:0]
    localparam int NV = 24;
    localparam logic [27:0] VEC [NV] = '{
        {4'd2,  3'd0, 3'd0, 1'b1, 1'b0, 8'h00, 8'hC3},  // R2 idle read
        {4'd2,  3'd1, 3'd1, 1'b1, 1'b0, 8'h00, 8'hC2},  // R2 read with program start
        {4'd3,  3'd0, 3'd1, 1'b1, 1'b0, 8'h35, 8'h80},  // R3 inverted msb
        {4'd8,  3'd0, 3'd1, 1'b1, 1'b1, 8'h35, 8'hE0},  // R8 timeout flag
        {4'd5,  3'd5, 3'd1, 1'b1, 1'b0, 8'h35, 8'h80},  // R5 bit 6 back to 0
        {4'd2,  3'd0, 3'd3, 1'b1, 1'b0, 8'h00, 8'hC0},  // R2 after finish
        {4'd2,  3'd2, 3'd0, 1'b1, 1'b0, 8'h00, 8'hC3},  // R2 read with erase start
        {4'd4,  3'd0, 3'd2, 1'b1, 1'b0, 8'h00, 8'h00},  // R4 window open
        {4'd6,  3'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h4C},  // R6 unselected sector
        {4'd6,  3'd0, 3'd5, 1'b0, 1'b0, 8'h00, 8'h0C},  // R6 selected sector
        {4'd5,  3'd3, 3'd5, 1'b0, 1'b0, 8'h00, 8'h48},  // R5 read with suspend
        {4'd7,  3'd0, 3'd2, 1'b0, 1'b0, 8'h00, 8'h84},  // R7 suspended sector
        {4'd6,  3'd0, 3'd2, 1'b0, 1'b0, 8'h00, 8'h80},  // R6 toggles while suspended
        {4'd2,  3'd0, 3'd4, 1'b0, 1'b0, 8'h00, 8'hC7},  // R2 other sector in suspend
        {4'd2,  3'd1, 3'd4, 1'b0, 1'b0, 8'h00, 8'hC7},  // R2 read with program start
        {4'd10, 3'd0, 3'd4, 1'b0, 1'b0, 8'hA5, 8'h00},  // R10 toggles cleared
        {4'd12, 3'd5, 3'd4, 1'b0, 1'b0, 8'hA5, 8'h40},  // R12 program in suspend
        {4'd7,  3'd0, 3'd5, 1'b0, 1'b0, 8'h00, 8'h80},  // R7 back in suspend
        {4'd6,  3'd4, 3'd5, 1'b0, 1'b0, 8'h00, 8'h84},  // R6 read with resume
        {4'd8,  3'd0, 3'd5, 1'b0, 1'b1, 8'h00, 8'h28},  // R8 erase timeout
        {4'd4,  3'd5, 3'd6, 1'b0, 1'b0, 8'h00, 8'h4C},  // R4 any address
        {4'd2,  3'd0, 3'd6, 1'b0, 1'b0, 8'h00, 8'hC5},  // R2 after erase
        {4'd11, 3'd3, 3'd1, 1'b0, 1'b0, 8'h00, 8'hC2},  // R11 suspend in idle
        {4'd11, 3'd0, 3'd1, 1'b0, 1'b0, 8'h00, 8'hC2}   // R11 still idle
    };

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            4'd11:   return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] e, input logic [2:0] s, input logic rd,
                        input logic w, input logic f, input logic [7:0] pb);
        op_evt    = e;
        rd_addr   = {s, 16'h0123};
        rd_stb    = rd;
        win_open  = w;
        time_fail = f;
        prog_byte = pb;
        @(posedge clk);
        @(negedge clk);
        op_evt = 3'd0;
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {7'd0, rd_valid}, 8'h00);
        chk("R1", rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][23:21], VEC[i][20:18], 1'b1, VEC[i][17], VEC[i][16], VEC[i][15:8]);
            chk("R2", {7'd0, rd_valid}, 8'h01);
            chk(req_name(VEC[i][27:24]), rd_data, VEC[i][7:0]);
        end

        // R11: suspend during program is ignored
        step(3'd1, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R2", {7'd0, rd_valid}, 8'h00);
        step(3'd3, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00);
        step(3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R11", rd_data, 8'h80);

        // R5: cycles without a strobe leave bit 6 alone
        step(3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00);
        step(3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00);
        step(3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R5", rd_data, 8'hC0);

        // R10: erase start in the same cycle as a read
        step(3'd5, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00);
        step(3'd2, 3'd2, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R10", rd_data, 8'hC1);
        step(3'd0, 3'd2, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R10", rd_data, 8'h00);

        // R9: status byte with every flag raised keeps bits 4,1,0 low
        step(3'd0, 3'd2, 1'b1, 1'b0, 1'b1, 8'h00);
        chk("R9", rd_data & 8'h13, 8'h00);
        chk("R4", rd_data, 8'h6C);
        step(3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule